// File: doc/BRIEF.md
# Rotate Group Execution Unit for a Prefixed 8-bit Opcode Page

This unit carries out the four single-bit rotate operations that sit at the start of an 8-bit CPU's second opcode page. It receives the second opcode byte with a one-cycle `start` strobe and splits the byte into an operation and an operand code. It rotates either a register-file entry or a byte in memory at the address held in the HL pair. It then updates its zero, subtract, half-carry and carry flags.

A register operand takes one cycle through the register-file read/write port. A memory operand runs as a read-modify-write sequence on a simple request/response memory port. The write goes back to the address that was read. Completion is signalled by a one-cycle `done` pulse together with the nominal cost of the instruction in clock cycles. Opcodes outside the rotate group are rejected with a one-cycle `illegal` pulse.

Top module: `prefix_rotate_unit`

## Requirements
- R1: Opcode bits [7:5] must be zero. Bits [4:3] pick the operation: 00 circular left, 01 circular right, 10 left through carry, 11 right through carry. Bits [2:0] pick the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A. The register-file index equals the code.
- R2: Circular left: the result is the operand moved left one place with old bit 7 in bit 0, and the new carry is old bit 7.
- R3: Circular right: the result is the operand moved right one place with old bit 0 in bit 7, and the new carry is old bit 0.
- R4: Left through carry: the result is the operand moved left one place with the old carry in bit 0, and the new carry is old bit 7.
- R5: Right through carry: the result is the operand moved right one place with the old carry in bit 7, and the new carry is old bit 0.
- R6: After each rotate, the zero flag is 1 exactly when the 8-bit result is zero, and the subtract and half-carry flags are 0.
- R7: A register rotate accepted at an edge drives `rf_wr_en` for exactly the next cycle, with the index and the result. `done` follows one cycle later, with `cycles` = 8 and the new flags visible.
- R8: A memory rotate drives `mem_rd_req` at the HL address from the cycle after start until the cycle in which `mem_rd_valid` is high. One idle cycle follows. Then `mem_wr_req` carries the result to the same address until the cycle in which `mem_wr_ack` is high. `done` comes two cycles after that cycle, with `cycles` = 16.
- R9: During a memory rotate the register file is not written, and the flags keep their old values until `done`.
- R10: A `start` with an opcode at or above 0x20 gives a one-cycle `illegal` pulse in the next cycle. It causes no register or memory access, no `done`, and no change to the flags.
- R11: A `start` while the unit is busy is ignored.
- R12: `busy` is high from the cycle after an accepted start up to, but not including, the `done` cycle. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `opcode` (taken only when idle) |
| opcode | input | 8 | Second opcode byte |
| hl | input | ADDR_W | HL pair, sampled at start |
| rf_rd_sel | output | 3 | Register-file read index |
| rf_rd_data | input | DATA_W | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_sel | output | 3 | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| mem_addr | output | ADDR_W | Memory address for read and write |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_rd_valid | input | 1 | Read data valid |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_wr_ack | input | 1 | Write accepted |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unsupported-opcode pulse |
| cycles | output | CYC_W | Nominal cost of the last completed operation |

## Verification
The bench builds the unit with its default parameters: 8-bit data, 16-bit addresses, costs of 8 and 16 cycles, and a 5-bit cost field. At these values 16 fits in the cost field and every operand code maps to a real register or to memory. The bench's memory responder varies the read and write latencies from zero to several cycles. This exercises the wait paths of the read-modify-write sequence and the flag hold across them. A sweep over all 32 legal opcodes with changing operand values drives the carry through both states for each rotate kind.

// File: rtl/rot_unit_pkg.sv
// Shared types for the rotate execution unit.
// Assumes: the operation code is the 2-bit field of the opcode, and operand 6 is memory.
package rot_unit_pkg;

    typedef enum logic [1:0] {
        ROT_LC = 2'b00,   // circular left
        ROT_RC = 2'b01,   // circular right
        ROT_LT = 2'b10,   // left through carry
        ROT_RT = 2'b11    // right through carry
    } rot_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REG,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    localparam logic [2:0] OPND_MEM = 3'd6;

endpackage

// File: rtl/rot_decode.sv
// Opcode splitter: separates the second opcode byte into legality, operation and operand.
// Assumes: only the lowest 32 codes belong to the rotate group.
module rot_decode
    import rot_unit_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       legal,
    output rot_op_e    op,
    output logic [2:0] sel
);

    // Field extraction from the opcode byte.
    assign legal = (opcode[7:5] == 3'b000);
    assign op    = rot_op_e'(opcode[4:3]);
    assign sel   = opcode[2:0];

endmodule

// File: rtl/rot_alu.sv
// Single-bit rotator: computes the result, the carry out and the zero indication for one operation.
// Assumes: DATA_W is at least 2; purely combinational.
module rot_alu
    import rot_unit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rot_op_e           op,
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              zero
);

    localparam int MSB = DATA_W - 1;

    // Rotate network chosen by operation.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            ROT_LC: begin res = {val[MSB-1:0], val[MSB]}; cout = val[MSB]; end
            ROT_RC: begin res = {val[0], val[MSB:1]};     cout = val[0];   end
            ROT_LT: begin res = {val[MSB-1:0], cin};      cout = val[MSB]; end
            ROT_RT: begin res = {cin, val[MSB:1]};        cout = val[0];   end
            default: ;
        endcase
    end

    // Zero detect on the result.
    assign zero = (res == '0);

    // Bit conservation checks: rotation only moves bits around.
    always_comb begin
        if (op == ROT_LC || op == ROT_RC) begin
            AST_CIRC_POPCOUNT: assert ($countones(res) == $countones(val)); // R2
        end else begin
            AST_THRU_POPCOUNT: assert ($countones(res) + int'(cout) == $countones(val) + int'(cin)); // R4
        end
    end

endmodule

// File: rtl/rot_seq.sv
// Sequencer: accepts a decoded operation and runs it as a one-cycle register update or a
// memory read-modify-write. It owns the flag register and reports completion and cost.
// Assumes: rf_rd_data is combinational on rf_rd_sel; memory holds rd_data while rd_valid is high.
module rot_seq
    import rot_unit_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int CYC_W      = 5,
    parameter int REG_CYCLES = 8,
    parameter int MEM_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dec_legal,
    input  rot_op_e           dec_op,
    input  logic [2:0]        dec_sel,
    input  logic [ADDR_W-1:0] hl,
    output logic [2:0]        rf_rd_sel,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [2:0]        rf_wr_sel,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_req,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              mem_wr_req,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output rot_op_e           alu_op,
    output logic [DATA_W-1:0] alu_in,
    output logic              alu_cin,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cout,
    input  logic              alu_zero,
    output flags_t            flags,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [CYC_W-1:0]  cycles
);

    seq_state_e        state_q;
    rot_op_e           op_q;
    logic [2:0]        sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] res_q;
    logic              pend_c_q;
    logic              pend_z_q;
    flags_t            flags_q;
    logic              done_q;
    logic              illegal_q;
    logic [CYC_W-1:0]  cycles_q;

    // State, operand capture, flag commit and completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= ROT_LC;
            sel_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            res_q     <= '0;
            pend_c_q  <= 1'b0;
            pend_z_q  <= 1'b0;
            flags_q   <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            cycles_q  <= '0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (!dec_legal) begin
                            illegal_q <= 1'b1;
                        end else begin
                            op_q    <= dec_op;
                            sel_q   <= dec_sel;
                            addr_q  <= hl;
                            state_q <= (dec_sel == OPND_MEM) ? ST_READ : ST_REG;
                        end
                    end
                end
                ST_REG: begin
                    flags_q  <= '{z: alu_zero, n: 1'b0, h: 1'b0, c: alu_cout};
                    done_q   <= 1'b1;
                    cycles_q <= CYC_W'(REG_CYCLES);
                    state_q  <= ST_IDLE;
                end
                ST_READ: begin
                    if (mem_rd_valid) begin
                        data_q  <= mem_rd_data;
                        state_q <= ST_MODIFY;
                    end
                end
                ST_MODIFY: begin
                    res_q    <= alu_res;
                    pend_c_q <= alu_cout;
                    pend_z_q <= alu_zero;
                    state_q  <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (mem_wr_ack) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    flags_q  <= '{z: pend_z_q, n: 1'b0, h: 1'b0, c: pend_c_q};
                    done_q   <= 1'b1;
                    cycles_q <= CYC_W'(MEM_CYCLES);
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operand routing into the shared rotator.
    always_comb begin
        alu_op  = op_q;
        alu_in  = (state_q == ST_REG) ? rf_rd_data : data_q;
        alu_cin = flags_q.c;
    end

    // Port driving for register file and memory.
    always_comb begin
        rf_rd_sel   = sel_q;
        rf_wr_en    = (state_q == ST_REG);
        rf_wr_sel   = sel_q;
        rf_wr_data  = alu_res;
        mem_addr    = addr_q;
        mem_rd_req  = (state_q == ST_READ);
        mem_wr_req  = (state_q == ST_WRITE);
        mem_wr_data = res_q;
    end

    assign flags   = flags_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign illegal = illegal_q;
    assign cycles  = cycles_q;

    AST_REG_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en); // R7

    AST_COST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles == (($past(state_q) == ST_REG) ? CYC_W'(REG_CYCLES) : CYC_W'(MEM_CYCLES)))); // R7

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R8

    AST_RF_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> !rf_wr_en); // R9

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_READ, ST_MODIFY, ST_WRITE}) |=> $stable(flags_q)); // R9

    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !done)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12

endmodule

// File: rtl/prefix_rotate_unit.sv
// Top level of the rotate execution unit: opcode splitter, shared rotator and sequencer.
// Assumes: the opcode is stable in the cycle start is high; the register file answers reads
// combinationally and the memory answers with a valid/ack handshake.
module prefix_rotate_unit
    import rot_unit_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int CYC_W      = 5,
    parameter int REG_CYCLES = 8,
    parameter int MEM_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] hl,
    output logic [2:0]        rf_rd_sel,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [2:0]        rf_wr_sel,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_req,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              mem_wr_req,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_h,
    output logic              flag_c,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [CYC_W-1:0]  cycles
);

    logic              dec_legal;
    rot_op_e           dec_op;
    logic [2:0]        dec_sel;
    rot_op_e           alu_op;
    logic [DATA_W-1:0] alu_in;
    logic              alu_cin;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout;
    logic              alu_zero;
    flags_t            flags;

    rot_decode u_decode (
        .opcode (opcode),
        .legal  (dec_legal),
        .op     (dec_op),
        .sel    (dec_sel)
    );

    rot_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (alu_op),
        .val  (alu_in),
        .cin  (alu_cin),
        .res  (alu_res),
        .cout (alu_cout),
        .zero (alu_zero)
    );

    rot_seq #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CYC_W      (CYC_W),
        .REG_CYCLES (REG_CYCLES),
        .MEM_CYCLES (MEM_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dec_legal    (dec_legal),
        .dec_op       (dec_op),
        .dec_sel      (dec_sel),
        .hl           (hl),
        .rf_rd_sel    (rf_rd_sel),
        .rf_rd_data   (rf_rd_data),
        .rf_wr_en     (rf_wr_en),
        .rf_wr_sel    (rf_wr_sel),
        .rf_wr_data   (rf_wr_data),
        .mem_addr     (mem_addr),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_valid (mem_rd_valid),
        .mem_wr_req   (mem_wr_req),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ack   (mem_wr_ack),
        .alu_op       (alu_op),
        .alu_in       (alu_in),
        .alu_cin      (alu_cin),
        .alu_res      (alu_res),
        .alu_cout     (alu_cout),
        .alu_zero     (alu_zero),
        .flags        (flags),
        .busy         (busy),
        .done         (done),
        .illegal      (illegal),
        .cycles       (cycles)
    );

    // Flag fan-out to individual pins.
    assign flag_z = flags.z;
    assign flag_n = flags.n;
    assign flag_h = flags.h;
    assign flag_c = flags.c;

endmodule

// File: tb/test_prefix_rotate_unit.sv
`timescale 1ns/1ps
// Bench: behavioural model of the rotate unit, with a register file and a memory responder.
// Inputs are driven and outputs sampled at the falling edge.
module test_prefix_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] hl = 16'h0000;
    logic [2:0]  rf_rd_sel;
    logic [7:0]  rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [7:0]  rf_wr_data;
    logic [15:0] mem_addr;
    logic        mem_rd_req;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        mem_rd_valid = 1'b0;
    logic        mem_wr_req;
    logic [7:0]  mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        flag_z, flag_n, flag_h, flag_c;
    logic        busy, done, illegal;
    logic [4:0]  cycles;

    logic [7:0] rf_m [8];
    int  n_checks = 0;
    int  n_err = 0;
    bit  mc = 1'b0;
    bit  mz = 1'b0;
    int  lcg = 17;

    always #2.5 clk = ~clk;

    prefix_rotate_unit i_prefix_rotate_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .hl(hl),
        .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data), .mem_addr(mem_addr),
        .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c),
        .busy(busy), .done(done), .illegal(illegal), .cycles(cycles)
    );

    assign rf_rd_data = rf_m[rf_rd_sel];

    always @(posedge clk) begin
        if (rf_wr_en) rf_m[rf_wr_sel] <= rf_wr_data;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string kind_req(input logic [7:0] opc);
        case (opc[4:3])
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Behavioural rotate: returns {carry, result}.
    function automatic logic [8:0] model_rot(input logic [7:0] opc, input logic [7:0] v, input bit cin);
        int x = int'(v);
        int r;
        int c;
        case (opc[4:3])
            2'd0: begin r = ((x * 2) + (x / 128)) % 256; c = x / 128; end
            2'd1: begin r = (x / 2) + (x % 2) * 128;     c = x % 2;   end
            2'd2: begin r = ((x * 2) % 256) + int'(cin); c = x / 128; end
            default: begin r = (x / 2) + int'(cin) * 128; c = x % 2; end
        endcase
        return {c[0], r[7:0]};
    endfunction

    function automatic logic [3:0] old_flags();
        return {mz, 1'b0, 1'b0, mc};
    endfunction

    task automatic do_reg(input logic [7:0] opc);
        logic [2:0] sel = opc[2:0];
        logic [8:0] m = model_rot(opc, rf_m[sel], mc);
        string kr = kind_req(opc);
        @(negedge clk);
        start = 1'b1; opcode = opc;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "rf_wr_en", rf_wr_en, 1);
        chk("R1", "rf_wr_sel", rf_wr_sel, sel);
        chk(kr, "rf_wr_data", rf_wr_data, m[7:0]);
        chk("R12", "busy", busy, 1);
        chk("R7", "flags before done", {flag_z, flag_n, flag_h, flag_c}, old_flags());
        @(negedge clk);
        chk("R7", "done", done, 1);
        chk("R7", "cycles", cycles, 8);
        chk("R7", "rf_wr_en after", rf_wr_en, 0);
        chk("R12", "busy at done", busy, 0);
        chk(kr, "carry", flag_c, m[8]);
        chk("R6", "zero", flag_z, (m[7:0] == 8'h00));
        chk("R6", "n,h", {flag_n, flag_h}, 0);
        chk(kr, "rf contents", rf_m[sel], m[7:0]);
        mc = m[8]; mz = (m[7:0] == 8'h00);
        @(negedge clk);
        chk("R12", "done one cycle", done, 0);
    endtask

    task automatic do_mem(input logic [7:0] opc, input logic [15:0] hlv, input logic [7:0] din,
                          input int rd_lat, input int wr_lat, input bit hold_start);
        logic [8:0] m = model_rot(opc, din, mc);
        string kr = kind_req(opc);
        @(negedge clk);
        start = 1'b1; opcode = opc; hl = hlv;
        @(negedge clk);
        if (hold_start) opcode = 8'h10; else start = 1'b0;
        chk("R8", "rd_req", mem_rd_req, 1);
        chk("R1", "mem operand addr", mem_addr, hlv);
        chk("R12", "busy", busy, 1);
        for (int k = 0; k < rd_lat; k++) begin
            @(negedge clk);
            chk("R8", "rd_req wait", mem_rd_req, 1);
            chk("R9", "rf quiet", rf_wr_en, 0);
            chk("R9", "flags held", {flag_z, flag_n, flag_h, flag_c}, old_flags());
        end
        mem_rd_valid = 1'b1; mem_rd_data = din;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk("R8", "modify gap", {mem_rd_req, mem_wr_req}, 0);
        chk("R9", "rf quiet modify", rf_wr_en, 0);
        @(negedge clk);
        chk("R8", "wr_req", mem_wr_req, 1);
        chk("R8", "wr addr", mem_addr, hlv);
        chk(kr, "wr_data", mem_wr_data, m[7:0]);
        chk("R9", "flags held", {flag_z, flag_n, flag_h, flag_c}, old_flags());
        for (int k = 0; k < wr_lat; k++) begin
            @(negedge clk);
            chk("R8", "wr_req wait", mem_wr_req, 1);
            chk("R11", "rf quiet", rf_wr_en, 0);
        end
        mem_wr_ack = 1'b1;
        @(negedge clk);
        mem_wr_ack = 1'b0;
        chk("R8", "wr_req dropped", mem_wr_req, 0);
        chk("R8", "no early done", done, 0);
        chk("R9", "flags held to commit", {flag_z, flag_n, flag_h, flag_c}, old_flags());
        @(negedge clk);
        start = 1'b0;
        chk("R8", "done", done, 1);
        chk("R8", "cycles", cycles, 16);
        chk(kr, "carry", flag_c, m[8]);
        chk("R6", "zero", flag_z, (m[7:0] == 8'h00));
        chk("R6", "n,h", {flag_n, flag_h}, 0);
        chk("R12", "busy at done", busy, 0);
        mc = m[8]; mz = (m[7:0] == 8'h00);
        @(negedge clk);
        chk("R12", "done one cycle", done, 0);
        chk("R11", "held start ignored", {busy, rf_wr_en}, 0);
    endtask

    task automatic do_illegal(input logic [7:0] opc);
        logic [7:0] snap [8];
        for (int i = 0; i < 8; i++) snap[i] = rf_m[i];
        @(negedge clk);
        start = 1'b1; opcode = opc;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "illegal", illegal, 1);
        chk("R10", "no activity", {busy, rf_wr_en, mem_rd_req, mem_wr_req, done}, 0);
        @(negedge clk);
        chk("R10", "illegal pulse", illegal, 0);
        chk("R10", "still idle", {busy, done}, 0);
        chk("R10", "flags unchanged", {flag_z, flag_n, flag_h, flag_c}, old_flags());
        for (int i = 0; i < 8; i++) chk("R10", "rf unchanged", rf_m[i], snap[i]);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rf_m[0] = 8'h80; rf_m[1] = 8'h55; rf_m[2] = 8'h01; rf_m[3] = 8'h81;
        rf_m[4] = 8'h01; rf_m[5] = 8'h00; rf_m[6] = 8'h00; rf_m[7] = 8'h80;
        repeat (3) @(negedge clk);
        chk("R12", "reset outputs", {busy, done, illegal, rf_wr_en, mem_rd_req, mem_wr_req}, 0);
        chk("R6", "reset flags", {flag_z, flag_n, flag_h, flag_c}, 0);
        chk("R7", "reset cycles", cycles, 0);
        rst_n = 1'b1;

        do_reg(8'h10);   // R4 B 0x80, carry in 0 -> zero result
        do_reg(8'h11);   // R4 C with carry in 1
        do_reg(8'h1A);   // R5 D
        do_reg(8'h1F);   // R5 A
        do_reg(8'h03);   // R2 E
        do_reg(8'h0C);   // R3 H
        do_reg(8'h0D);   // R3 L zero operand

        do_mem(8'h16, 16'hC0DE, 8'h80, 0, 0, 1'b0);  // R8 left through carry
        do_mem(8'h1E, 16'h1234, 8'h01, 2, 3, 1'b1);  // R11 start held while busy
        do_mem(8'h06, 16'hFFFF, 8'h81, 1, 0, 1'b0);
        do_mem(8'h0E, 16'h0000, 8'h00, 0, 2, 1'b0);

        do_illegal(8'h20);
        do_illegal(8'hFF);

        for (int o = 0; o < 32; o++) begin
            if (o % 8 != 6) begin
                lcg = (lcg * 109 + 89) % 251;
                @(negedge clk);
                rf_m[o % 8] = 8'(lcg);
                do_reg(8'(o));
            end else begin
                lcg = (lcg * 109 + 89) % 251;
                do_mem(8'(o), 16'(lcg * 37), 8'(lcg), o / 8, 1, 1'b0);
            end
        end
        do_illegal(8'h40);
        finish_run();
    end

endmodule